// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This unit gives an embedded core three timers that share one control register and one status register. The programmable interval timer counts down from a reload value on each enabled tick. It can restart itself from that value or stop after one period. The fixed interval timer raises an event on each rising edge of a selected bit of the free-running 64-bit time base.

The watchdog also watches a selectable time-base bit. Each watched edge moves it one step further along a three-step path. The first edge arms it. The second edge raises an interrupt. Every edge after that records a reset type in the status register and asks for a reset. Software restarts the watchdog path by clearing status bits, which are cleared by writing ones to them.

Software reaches the registers through a single-cycle write port and a combinational read port, both selected by a 2-bit code. The block drives three interrupt lines, a one-cycle reset request and a 2-bit reset type. Turning that type into an actual core, chip or system reset is left to the logic around the block.

Top module: `emb_timer_unit`

## Requirements
- R1: While `rst_n` is low every register clears. All three registers read 0, and `pit_irq`, `fit_irq`, `wdt_irq`, `rst_req` and `rst_kind` are 0.
- R2: The register select codes are 0 for control, 1 for status and 2 for the interval timer count. Reading code 2 returns the current count. Code 3 reads 0 and writes to it change nothing. A control write keeps data bits 31:22 and reads back 0 in bits 21:0.
- R3: Writing the status register clears each of status bits 31:26 whose data bit is 1. Status bits 25:0 read 0. If a timer event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R4: A status write with data bit 31 set drops `pit_irq`. A status write that leaves bit 31 at 0 does not change `pit_irq`.
- R5: While the interval timer runs, each cycle with `tick` high lowers the count by one. A tick that finds the count at 1 is an expiry: it sets status bit 27 and raises `pit_irq`, which stays high until it is dropped as in R4. Cycles with `tick` low leave the count unchanged.
- R6: On expiry, if control bit 22 (auto-reload) is 1, the count reloads from the reload value and the timer keeps running. Otherwise the count becomes 0 and the timer stops.
- R7: Writing code 2 stores the data as both the reload value and the count. The timer then runs only if the data is greater than 1 and control bit 26 (interval interrupt enable) is 1. A control write with bit 26 at 0 stops a running timer. A control write never starts a stopped timer.
- R8: Control bits 25:24 select which time-base bit the fixed interval timer watches: 0 selects bit 9, 1 bit 13, 2 bit 17 and 3 bit 21. Each 0-to-1 transition of that bit sets status bit 26. A bit that stays high causes no further events.
- R9: Control bits 31:30 select which time-base bit the watchdog watches: 0 selects bit 17, 1 bit 21, 2 bit 25 and 3 bit 29. On each 0-to-1 transition of that bit the watchdog acts on the current status. If bit 31 is 0, it sets bit 31. If bit 31 is 1 and bit 30 is 0, it sets bit 30. If both are 1, it takes the final step of R11.
- R10: `fit_irq` is high exactly when status bit 26 and control bit 23 are both 1. `wdt_irq` is high exactly when status bit 30 and control bit 27 are both 1.
- R11: On the final step the block copies control bits 29:28 into status bits 29:28. These bits encode the reset type: 0 none, 1 core, 2 chip, 3 system. `rst_kind` always shows status bits 29:28. When the copied type is not 0, `rst_req` is high for exactly the one cycle after the step. When it is 0, `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for the interval timer |
| tbase | input | 64 | Free-running time base; supplies the tapped bits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 interval count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source, same coding as `wr_sel` |
| rd_data | output | 32 | Read data (combinational) |
| pit_irq | output | 1 | Interval timer interrupt request |
| fit_irq | output | 1 | Fixed interval interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset type recorded on the last final watchdog step |

## Verification
The bench targets the interval timer's edge values. A reload of 1 must never run; a design that let it run would keep setting status bit 27. A one-shot expiry must leave the count parked at 0, and a design that wrapped the count would keep expiring. It also checks that only status bit 31, not bit 27, releases the interval interrupt; a design tied to bit 27 would drop `pit_irq` on the wrong write. The watchdog is walked through all three steps and then through a final step whose type is 0. A design that skipped a step would reset one edge early, and a design that pulsed without a type would assert `rst_req` with `rst_kind` at 0. A status clear that lands in the same cycle as a fixed interval edge must leave the bit set; a design that let the clear win would drop a real event.

// File: rtl/emb_timer_unit.sv
module emb_timer_unit #(
  parameter int TB_W     = 64,
  parameter int FIT_TAP0 = 9,
  parameter int WDT_TAP0 = 17,
  parameter int TAP_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [TB_W-1:0] tbase,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [1:0]      rd_sel,
  output logic [31:0]     rd_data,
  output logic            pit_irq,
  output logic            fit_irq,
  output logic            wdt_irq,
  output logic            rst_req,
  output logic [1:0]      rst_kind
);
  localparam int NTAP = 4;

  logic [31:22] ctl_q;
  logic [31:26] sts_q, sts_d;
  logic [31:0]  reload_q, cnt_q;
  logic         run_q, pit_irq_q, rst_req_q;
  logic [NTAP-1:0] fit_now, fit_prev, wdt_now, wdt_prev;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign fit_now[i] = tbase[FIT_TAP0 + i*TAP_STEP];
    assign wdt_now[i] = tbase[WDT_TAP0 + i*TAP_STEP];
  end

  logic unused_tbase;
  assign unused_tbase = ^tbase;

  logic wr_ctl, wr_sts, wr_pit, ctl_stop, pit_exp, fit_evt, wdt_evt, wdt_fire;
  assign wr_ctl   = wr_en && (wr_sel == 2'd0);
  assign wr_sts   = wr_en && (wr_sel == 2'd1);
  assign wr_pit   = wr_en && (wr_sel == 2'd2);
  assign ctl_stop = wr_ctl && !wr_data[26];
  assign pit_exp  = run_q && tick && (cnt_q == 32'd1) && !wr_pit && !ctl_stop;
  assign fit_evt  = fit_now[ctl_q[25:24]] && !fit_prev[ctl_q[25:24]];
  assign wdt_evt  = wdt_now[ctl_q[31:30]] && !wdt_prev[ctl_q[31:30]];
  assign wdt_fire = wdt_evt && sts_q[31] && sts_q[30];

  always_comb begin
    sts_d = sts_q & ~(wr_sts ? wr_data[31:26] : 6'b0);
    if (fit_evt) sts_d[26] = 1'b1;
    if (pit_exp) sts_d[27] = 1'b1;
    if (wdt_evt) begin
      if (!sts_q[31])      sts_d[31] = 1'b1;
      else if (!sts_q[30]) sts_d[30] = 1'b1;
      else                 sts_d[29:28] = ctl_q[29:28];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      sts_q     <= '0;
      fit_prev  <= '0;
      wdt_prev  <= '0;
      rst_req_q <= 1'b0;
      pit_irq_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= wr_data[31:22];
      sts_q     <= sts_d;
      fit_prev  <= fit_now;
      wdt_prev  <= wdt_now;
      rst_req_q <= wdt_fire && (ctl_q[29:28] != 2'b00);
      if (pit_exp)                  pit_irq_q <= 1'b1;
      else if (wr_sts && wr_data[31]) pit_irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
    end else if (wr_pit) begin
      reload_q <= wr_data;
      cnt_q    <= wr_data;
      run_q    <= (wr_data > 32'd1) && ctl_q[26];
    end else if (ctl_stop) begin
      run_q <= 1'b0;
    end else if (pit_exp) begin
      if (ctl_q[22]) cnt_q <= reload_q;
      else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - 32'd1;
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {ctl_q, 22'b0};
      2'd1:    rd_data = {sts_q, 26'b0};
      2'd2:    rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end

  assign pit_irq  = pit_irq_q;
  assign fit_irq  = sts_q[26] && ctl_q[23];
  assign wdt_irq  = sts_q[30] && ctl_q[27];
  assign rst_req  = rst_req_q;
  assign rst_kind = sts_q[29:28];
endmodule

// File: rtl/emb_timer_unit_chk.sv
module emb_timer_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        run,
  input logic [31:0] reload,
  input logic [31:0] cnt,
  input logic [31:26] sts,
  input logic        rst_req,
  input logic        wr_en
);
  AST_PIT_EXP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == 32'd1 && !wr_en) |=> sts[27]); // R5
  AST_PIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt)); // R5
  AST_PIT_RUN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> reload > 32'd1); // R7
  AST_WIS_AFTER_ENW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[30]) |-> $past(sts[31])); // R9
  AST_RST_AFTER_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(sts[31] && sts[30])); // R11
  AST_RST_KIND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> sts[29:28] != 2'b00); // R11
endmodule

bind emb_timer_unit emb_timer_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q), .reload(reload_q),
  .cnt(cnt_q), .sts(sts_q), .rst_req(rst_req_q), .wr_en(wr_en)
);

// File: tb/emb_timer_unit_tb.sv
`timescale 1ns/1ps
module emb_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [63:0] tbase = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        pit_irq, fit_irq, wdt_irq, rst_req;
  logic [1:0]  rst_kind;

  always #2.5 clk = ~clk;

  emb_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tbase(tbase),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .pit_irq(pit_irq), .fit_irq(fit_irq),
    .wdt_irq(wdt_irq), .rst_req(rst_req), .rst_kind(rst_kind)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit started = 0;
  bit done = 0;

  // behavioural reference model
  logic [31:0] m_ctl, m_sts, m_rel, m_cnt;
  logic [63:0] m_prev;
  bit m_run, m_pirq, m_rreq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_sts = 0; m_rel = 0; m_cnt = 0; m_prev = 0;
      m_run = 0; m_pirq = 0; m_rreq = 0;
    end else begin
      int fb, wb;
      bit fe, we, ex, wc, ws, wp;
      logic [31:0] ns;
      fb = 9 + 4 * int'(m_ctl[25:24]);
      wb = 17 + 4 * int'(m_ctl[31:30]);
      fe = tbase[fb] && !m_prev[fb];
      we = tbase[wb] && !m_prev[wb];
      wc = wr_en && wr_sel == 0;
      ws = wr_en && wr_sel == 1;
      wp = wr_en && wr_sel == 2;
      ex = m_run && tick && m_cnt == 1 && !wp && !(wc && !wr_data[26]);
      ns = m_sts;
      if (ws) ns = ns & ~(wr_data & 32'hFC00_0000);
      if (fe) ns[26] = 1;
      if (ex) ns[27] = 1;
      m_rreq = 0;
      if (we) begin
        if (!m_sts[31]) ns[31] = 1;
        else if (!m_sts[30]) ns[30] = 1;
        else begin
          ns[29:28] = m_ctl[29:28];
          m_rreq = (m_ctl[29:28] != 0);
        end
      end
      if (ex) m_pirq = 1;
      else if (ws && wr_data[31]) m_pirq = 0;
      if (wp) begin
        m_rel = wr_data; m_cnt = wr_data;
        m_run = (wr_data > 1) && m_ctl[26];
      end else if (wc && !wr_data[26]) m_run = 0;
      else if (ex) begin
        if (m_ctl[22]) m_cnt = m_rel;
        else begin m_cnt = 0; m_run = 0; end
      end else if (m_run && tick) m_cnt = m_cnt - 1;
      if (wc) m_ctl = wr_data & 32'hFFC0_0000;
      m_sts = ns;
      m_prev = tbase;
    end
    started = 1;
  end

  always @(posedge clk) begin
    #1;
    if (started && !done) begin
      logic [37:0] got, exp;
      logic [31:0] erd;
      case (rd_sel)
        2'd0: erd = m_ctl;
        2'd1: erd = m_sts;
        2'd2: erd = m_cnt;
        default: erd = 0;
      endcase
      exp = {m_pirq, m_sts[26] & m_ctl[23], m_sts[30] & m_ctl[27], m_rreq, m_sts[29:28], erd};
      got = {pit_irq, fit_irq, wdt_irq, rst_req, rst_kind, rd_data};
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s model compare: got %h expected %h", phase, got, exp);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd_sel = s;
    @(posedge clk); #1 v = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic pulse_bit(input int b);
    @(negedge clk); tbase = '0;
    @(negedge clk); tbase = 64'd1 << b;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rdreg(2'd0, v); chk("R1 ctl", v, 0);
    rdreg(2'd1, v); chk("R1 sts", v, 0);
    rdreg(2'd2, v); chk("R1 cnt", v, 0);
    chk("R1 outs", {27'd0, pit_irq, fit_irq, wdt_irq, rst_req, rst_kind != 0}, 0);
    @(negedge clk); rst_n = 1;

    phase = "R2";
    wr(2'd0, 32'hFFFF_FFFF);
    rdreg(2'd0, v); chk("R2 ctl keeps 31:22", v, 32'hFFC0_0000);
    wr(2'd3, 32'h1234_5678);
    rdreg(2'd3, v); chk("R2 code 3 reads 0", v, 0);
    rdreg(2'd0, v); chk("R2 code 3 write ignored", v, 32'hFFC0_0000);
    wr(2'd0, 32'h0);

    phase = "R7";
    wr(2'd0, 32'h0400_0000);
    wr(2'd2, 32'd1);
    ticks(10);
    rdreg(2'd2, v); chk("R7 reload 1 stays stopped", v, 1);
    rdreg(2'd1, v); chk("R7 no expiry at reload 1", v, 0);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd5);
    ticks(8);
    rdreg(2'd2, v); chk("R7 disabled keeps count", v, 5);
    wr(2'd0, 32'h0400_0000);
    ticks(3);
    rdreg(2'd2, v); chk("R7 control write does not start", v, 5);

    phase = "R5";
    wr(2'd2, 32'd4);
    repeat (5) @(negedge clk);
    rdreg(2'd2, v); chk("R5 no tick no count", v, 4);
    wr(2'd2, 32'd3);
    ticks(2);
    rdreg(2'd2, v); chk("R5 counted down", v, 1);
    chk("R5 no irq before expiry", {31'd0, pit_irq}, 0);
    ticks(1);
    chk("R5 irq on expiry", {31'd0, pit_irq}, 1);
    rdreg(2'd1, v); chk("R5 status 27", v, 32'h0800_0000);
    phase = "R6";
    ticks(4);
    rdreg(2'd2, v); chk("R6 one-shot parks at 0", v, 0);

    phase = "R4";
    wr(2'd1, 32'h0800_0000);
    rdreg(2'd1, v); chk("R3 clear bit 27", v, 0);
    chk("R4 bit 27 write keeps irq", {31'd0, pit_irq}, 1);
    wr(2'd1, 32'h8000_0000);
    chk("R4 bit 31 write drops irq", {31'd0, pit_irq}, 0);

    phase = "R6";
    wr(2'd0, 32'h0440_0000);
    wr(2'd2, 32'd2);
    ticks(5);
    rdreg(2'd2, v); chk("R6 auto-reload count", v, 1);
    rdreg(2'd1, v); chk("R6 status after reloads", v, 32'h0800_0000);
    phase = "R7";
    wr(2'd0, 32'h0040_0000);
    ticks(4);
    rdreg(2'd2, v); chk("R7 control write stops timer", v, 1);
    wr(2'd1, 32'hFC00_0000);

    phase = "R8";
    wr(2'd0, 32'h0180_0000);
    pulse_bit(9);
    rdreg(2'd1, v); chk("R8 unselected bit ignored", v, 0);
    chk("R10 fit irq low", {31'd0, fit_irq}, 0);
    pulse_bit(13);
    rdreg(2'd1, v); chk("R8 fit event", v, 32'h0400_0000);
    chk("R10 fit irq high", {31'd0, fit_irq}, 1);
    wr(2'd1, 32'h0400_0000);
    repeat (3) @(negedge clk);
    rdreg(2'd1, v); chk("R8 held bit no event", v, 0);
    phase = "R3";
    @(negedge clk); tbase = '0;
    @(negedge clk); tbase = 64'd1 << 13;
    wr_en = 1; wr_sel = 2'd1; wr_data = 32'h0400_0000;
    @(negedge clk); wr_en = 0;
    rdreg(2'd1, v); chk("R3 set wins over clear", v, 32'h0400_0000);
    wr(2'd1, 32'hFC00_0000);
    @(negedge clk); tbase = '0;

    phase = "R9";
    wr(2'd0, 32'hA800_0000);
    pulse_bit(21);
    rdreg(2'd1, v); chk("R9 wrong tap ignored", v, 0);
    pulse_bit(25);
    rdreg(2'd1, v); chk("R9 first step", v, 32'h8000_0000);
    chk("R10 wdt irq low", {31'd0, wdt_irq}, 0);
    pulse_bit(25);
    rdreg(2'd1, v); chk("R9 second step", v, 32'hC000_0000);
    chk("R10 wdt irq high", {31'd0, wdt_irq}, 1);
    phase = "R11";
    @(negedge clk); tbase = '0;
    @(negedge clk); tbase = 64'd1 << 25;
    @(posedge clk); #1;
    chk("R11 reset pulse", {31'd0, rst_req}, 1);
    chk("R11 reset type chip", {30'd0, rst_kind}, 2);
    @(posedge clk); #1;
    chk("R11 pulse one cycle", {31'd0, rst_req}, 0);
    rdreg(2'd1, v); chk("R11 type in status", v, 32'hE000_0000);
    wr(2'd0, 32'h8800_0000);
    @(negedge clk); tbase = '0;
    @(negedge clk); tbase = 64'd1 << 25;
    @(posedge clk); #1;
    chk("R11 type 0 no pulse", {31'd0, rst_req}, 0);
    rdreg(2'd1, v); chk("R11 type 0 recorded", v, 32'hC000_0000);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule